// File: doc/BRIEF.md
# Indirect Data Memory Pointer Unit

This block holds two independent 12-bit pointers that an 8-bit microcontroller data path uses to reach its data memory indirectly. Each pointer is stored as a 4-bit upper part and an 8-bit lower part. Software sets these parts with direct byte writes. It then reaches memory through one of five access modes per pointer. Each mode drives a memory address and read/write strobes in the same cycle and may adjust the pointer at the end of that cycle.

The five modes are:
- plain access;
- access then step up;
- access then step down;
- step up then access;
- pointer plus the working register, with the pointer left as it is.

The access modes are virtual and hold no state; only the two pointer parts of each pointer are registers. The current pointer values are exported so that the surrounding data path can read them back. The data memory, the instruction decoder and any bank selection sit outside this block.

Top module: `ind_ptr_unit`

## Requirements
- R1: While `rst_n` is low, bits 11:8 of every pointer clear to 0, and bits 7:0 keep their value across that reset.
- R2: With `acc_en` high and `acc_mode` = 0 (plain), `mem_addr` equals the selected pointer in that cycle, and the pointer is unchanged afterwards.
- R3: With `acc_mode` = 1 (post-step-up), `mem_addr` equals the current pointer, and the pointer is one higher after the clock edge.
- R4: With `acc_mode` = 2 (post-step-down), `mem_addr` equals the current pointer, and the pointer is one lower after the clock edge.
- R5: With `acc_mode` = 3 (pre-step-up), `mem_addr` equals the pointer plus one in that cycle, and the pointer holds that same value after the edge.
- R6: With `acc_mode` = 4 (offset), `mem_addr` equals the pointer plus the unsigned 8-bit `wreg`, modulo 4096, and the pointer is unchanged.
- R7: Stepping wraps over the full 12 bits: 0xFFF+1 gives 0x000, 0x000-1 gives 0xFFF, and a carry out of bits 7:0 reaches bits 11:8 (0x0FF+1 gives 0x100).
- R8: A direct write with `dw_hi`=1 loads `dw_data[3:0]` into bits 11:8 of pointer `dw_sel`. A direct write with `dw_hi`=0 loads `dw_data` into bits 7:0. In both cases the new value is visible after the clock edge.
- R9: A direct write to the pointer being accessed in the same cycle wins over the mode's step. Only the written byte changes, and no step is applied.
- R10: An access or a direct write to one pointer never changes the other pointer. An access to one pointer and a direct write to the other in the same cycle both take effect.
- R11: `mem_rd` = `acc_en` & ~`acc_we` and `mem_wr` = `acc_en` & `acc_we`, and `mem_wdata` carries `acc_wdata`. Mode codes 5 to 7 raise no strobe and change no pointer.
- R12: Back-to-back accesses in consecutive cycles each see the pointer as updated by the access before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_en | input | 1 | Alias access strobe |
| acc_sel | input | 1 | Pointer addressed by the access |
| acc_mode | input | 3 | Access mode: 0 plain, 1 post-up, 2 post-down, 3 pre-up, 4 offset |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_wdata | input | 8 | Data for a write access |
| dw_en | input | 1 | Direct pointer byte write strobe |
| dw_sel | input | 1 | Pointer addressed by the direct write |
| dw_hi | input | 1 | 1 = upper part, 0 = lower byte |
| dw_data | input | 8 | Direct write data |
| wreg | input | 8 | Working register value |
| mem_addr | output | 12 | Data memory address |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write data |
| ptr_vals | output | 24 | Pointer values, pointer 0 in bits 11:0, pointer 1 in bits 23:12 |

## Verification
The assertions assume that `acc_mode`, `acc_sel` and the direct write inputs are stable and known around each rising edge. They also assume that a pointer's lower byte has been loaded before any step or offset on it is checked, because that byte is not cleared by reset. The directed stimulus loads every pointer fully with direct writes before accessing it. It changes inputs only at falling edges and returns all strobes to zero between scenarios. That way each property starts from a defined pointer value.

// File: rtl/iptr_pkg.sv
package iptr_pkg;

    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_POSTDEC = 3'd2,
        AM_PREINC  = 3'd3,
        AM_OFFSET  = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_INC  = 2'd1,
        UPD_DEC  = 2'd2
    } upd_e;

endpackage

// File: rtl/iptr_decode.sv
module iptr_decode
    import iptr_pkg::*;
(
    input  logic       acc_en_i,
    input  logic [2:0] acc_mode_i,
    input  logic       acc_we_i,
    output logic       valid_o,
    output upd_e       upd_o,
    output logic       use_pre_o,
    output logic       use_off_o,
    output logic       mem_rd_o,
    output logic       mem_wr_o
);

    always_comb begin
        valid_o   = 1'b0;
        upd_o     = UPD_NONE;
        use_pre_o = 1'b0;
        use_off_o = 1'b0;
        if (acc_en_i) begin
            case (acc_mode_i)
                AM_PLAIN:   valid_o = 1'b1;
                AM_POSTINC: begin valid_o = 1'b1; upd_o = UPD_INC; end
                AM_POSTDEC: begin valid_o = 1'b1; upd_o = UPD_DEC; end
                AM_PREINC:  begin valid_o = 1'b1; upd_o = UPD_INC; use_pre_o = 1'b1; end
                AM_OFFSET:  begin valid_o = 1'b1; use_off_o = 1'b1; end
                default:    valid_o = 1'b0;
            endcase
        end
        mem_rd_o = valid_o & ~acc_we_i;
        mem_wr_o = valid_o &  acc_we_i;
    end

endmodule

// File: rtl/iptr_slot.sv
module iptr_slot
    import iptr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_e              upd_i,
    input  logic              wr_en_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
    } slot_t;

    slot_t st_d, st_q;
    logic [ADDR_W-1:0] full_inc, full_dec;

    always_comb begin
        full_inc = ADDR_W'({st_q.hi, st_q.lo} + ADDR_W'(1));
        full_dec = ADDR_W'({st_q.hi, st_q.lo} - ADDR_W'(1));
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_hi_i) st_d.hi = wr_data_i[HI_W-1:0];
            else         st_d.lo = wr_data_i;
        end else begin
            case (upd_i)
                UPD_INC: st_d = slot_t'(full_inc);
                UPD_DEC: st_d = slot_t'(full_dec);
                default: st_d = st_q;
            endcase
        end
    end

    // upper part clears on reset, lower byte holds its value
    always_ff @(posedge clk) begin
        if (!rst_n) st_q.hi <= '0;
        else        st_q    <= st_d;
    end

    assign ptr_o = {st_q.hi, st_q.lo};

    // R1: reset clears the upper part
    p_reset_hi_r1: assert property (@(posedge clk) !rst_n |=> ptr_o[ADDR_W-1:DATA_W] == '0);

    // R3, R5, R7: a step up adds one, wrapping across all bits
    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i == UPD_INC && !wr_en_i) |=> ptr_o == ADDR_W'($past(ptr_o) + 1'b1));

    // R4, R7: a step down subtracts one, wrapping across all bits
    p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i == UPD_DEC && !wr_en_i) |=> ptr_o == ADDR_W'($past(ptr_o) - 1'b1));

    // R2, R6, R10: no step and no write leaves the pointer as it is
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i == UPD_NONE && !wr_en_i) |=> $stable(ptr_o));

    // R8: a lower byte write lands in bits 7:0
    p_wr_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_hi_i) |=> ptr_o[DATA_W-1:0] == $past(wr_data_i));

    // R9: an upper write keeps the lower byte despite any step request
    p_wr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_hi_i) |=> ptr_o[DATA_W-1:0] == $past(ptr_o[DATA_W-1:0]));

endmodule

// File: rtl/iptr_addr.sv
module iptr_addr #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter int NUM_PTR = 2,
    parameter int PSEL_W  = 1
) (
    input  logic [NUM_PTR*ADDR_W-1:0] ptr_all_i,
    input  logic [PSEL_W-1:0]         sel_i,
    input  logic                      use_pre_i,
    input  logic                      use_off_i,
    input  logic [DATA_W-1:0]         wreg_i,
    output logic [ADDR_W-1:0]         addr_o
);

    logic [ADDR_W-1:0] base;

    always_comb begin
        base = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (int'(sel_i) == i) base = ptr_all_i[i*ADDR_W +: ADDR_W];
        end
        if (use_off_i)      addr_o = ADDR_W'(base + ADDR_W'(wreg_i));
        else if (use_pre_i) addr_o = ADDR_W'(base + ADDR_W'(1));
        else                addr_o = base;
    end

endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit
    import iptr_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter int NUM_PTR = 2,
    localparam int PSEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_en,
    input  logic [PSEL_W-1:0]         acc_sel,
    input  logic [2:0]                acc_mode,
    input  logic                      acc_we,
    input  logic [DATA_W-1:0]         acc_wdata,
    input  logic                      dw_en,
    input  logic [PSEL_W-1:0]         dw_sel,
    input  logic                      dw_hi,
    input  logic [DATA_W-1:0]         dw_data,
    input  logic [DATA_W-1:0]         wreg,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic [NUM_PTR*ADDR_W-1:0] ptr_vals
);

    logic valid, use_pre, use_off;
    upd_e upd;

    iptr_decode u_dec (
        .acc_en_i   (acc_en),
        .acc_mode_i (acc_mode),
        .acc_we_i   (acc_we),
        .valid_o    (valid),
        .upd_o      (upd),
        .use_pre_o  (use_pre),
        .use_off_o  (use_off),
        .mem_rd_o   (mem_rd),
        .mem_wr_o   (mem_wr)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
        upd_e slot_upd;
        logic slot_wr;
        assign slot_upd = (valid && int'(acc_sel) == g) ? upd : UPD_NONE;
        assign slot_wr  = dw_en && (int'(dw_sel) == g);
        iptr_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_i     (slot_upd),
            .wr_en_i   (slot_wr),
            .wr_hi_i   (dw_hi),
            .wr_data_i (dw_data),
            .ptr_o     (ptr_vals[g*ADDR_W +: ADDR_W])
        );
    end

    iptr_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .PSEL_W(PSEL_W)) u_addr (
        .ptr_all_i (ptr_vals),
        .sel_i     (acc_sel),
        .use_pre_i (use_pre),
        .use_off_i (use_off),
        .wreg_i    (wreg),
        .addr_o    (mem_addr)
    );

    assign mem_wdata = acc_wdata;

    logic [ADDR_W-1:0] cur_ptr;
    always_comb begin
        cur_ptr = '0;
        for (int i = 0; i < NUM_PTR; i++)
            if (int'(acc_sel) == i) cur_ptr = ptr_vals[i*ADDR_W +: ADDR_W];
    end

    // R2, R3, R4: plain and post modes address with the current pointer
    p_cur_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode <= 3'd2) |-> mem_addr == cur_ptr);

    // R5: pre-step mode addresses the value the pointer takes next
    p_pre_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 3'd3 && !dw_en) |=> $past(mem_addr) == cur_ptr);

    // R6: offset mode adds the working register
    p_off_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 3'd4) |-> mem_addr == ADDR_W'(cur_ptr + ADDR_W'(wreg)));

    // R11: unused mode codes raise no strobe
    p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode > 3'd4 || !acc_en) |-> (!mem_rd && !mem_wr));

    // R11: strobes never both active
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/sim_ind_ptr_unit.sv
module sim_ind_ptr_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_en, acc_sel, acc_we;
    logic [2:0]  acc_mode;
    logic [7:0]  acc_wdata;
    logic        dw_en, dw_sel, dw_hi;
    logic [7:0]  dw_data, wreg;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [23:0] ptr_vals;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ind_ptr_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_en(acc_en), .acc_sel(acc_sel), .acc_mode(acc_mode), .acc_we(acc_we),
        .acc_wdata(acc_wdata),
        .dw_en(dw_en), .dw_sel(dw_sel), .dw_hi(dw_hi), .dw_data(dw_data),
        .wreg(wreg),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .ptr_vals(ptr_vals)
    );

    function automatic logic [11:0] pv(input bit p);
        return p ? ptr_vals[23:12] : ptr_vals[11:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        acc_en = 1'b0; dw_en = 1'b0;
    endtask

    task automatic setp(input bit p, input logic [11:0] v);
        acc_en = 1'b0;
        dw_en = 1'b1; dw_sel = p; dw_hi = 1'b1; dw_data = {4'h0, v[11:8]};
        step();
        dw_hi = 1'b0; dw_data = v[7:0];
        step();
        dw_en = 1'b0;
    endtask

    // one access cycle; checks the combinational outputs mid-cycle
    task automatic acc(input string req, input bit p, input logic [2:0] m, input bit we,
                       input logic [7:0] wd, input logic [11:0] exp_addr);
        acc_en = 1'b1; acc_sel = p; acc_mode = m; acc_we = we; acc_wdata = wd;
        #1;
        check(req, mem_addr, exp_addr);
        check("R11", {mem_rd, mem_wr}, {~we, we});
        if (we) check("R11", mem_wdata, wd);
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); wreg = 8'h00; acc_sel = 1'b0; acc_mode = 3'd0;
        acc_we = 1'b0; acc_wdata = 8'h00; dw_sel = 1'b0; dw_hi = 1'b0; dw_data = 8'h00;
        step(); step();
        check("R1", pv(0) >> 8, 0);
        check("R1", pv(1) >> 8, 0);
        rst_n = 1'b1;
        step();
        setp(0, 12'h3A5);
        rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
        check("R1", pv(0), 12'h0A5);
    endtask

    task automatic t_direct();
        setp(0, 12'h123);
        check("R8", pv(0), 12'h123);
        dw_en = 1'b1; dw_sel = 1'b1; dw_hi = 1'b1; dw_data = 8'hF7; step();
        dw_hi = 1'b0; dw_data = 8'h00; step(); idle();
        check("R8", pv(1), 12'h700);
        check("R10", pv(0), 12'h123);
    endtask

    task automatic t_modes();
        acc("R2", 0, 3'd0, 1'b0, 8'h00, 12'h123); idle();
        check("R2", pv(0), 12'h123);
        acc("R3", 0, 3'd1, 1'b1, 8'h5C, 12'h123); idle();
        check("R3", pv(0), 12'h124);
        acc("R12", 0, 3'd1, 1'b0, 8'h00, 12'h124);
        acc("R12", 0, 3'd1, 1'b0, 8'h00, 12'h125); idle();
        check("R12", pv(0), 12'h126);
        acc("R4", 0, 3'd2, 1'b0, 8'h00, 12'h126); idle();
        check("R4", pv(0), 12'h125);
        acc("R5", 0, 3'd3, 1'b1, 8'hA1, 12'h126); idle();
        check("R5", pv(0), 12'h126);
        wreg = 8'hF0;
        acc("R6", 0, 3'd4, 1'b0, 8'h00, 12'h216); idle();
        check("R6", pv(0), 12'h126);
        check("R10", pv(1), 12'h700);
        setp(1, 12'hFF0); wreg = 8'h20;
        acc("R6", 1, 3'd4, 1'b0, 8'h00, 12'h010); idle();
        check("R6", pv(1), 12'hFF0);
    endtask

    task automatic t_wrap();
        setp(1, 12'hFFF);
        acc("R7", 1, 3'd1, 1'b0, 8'h00, 12'hFFF); idle();
        check("R7", pv(1), 12'h000);
        acc("R7", 1, 3'd2, 1'b0, 8'h00, 12'h000); idle();
        check("R7", pv(1), 12'hFFF);
        setp(0, 12'h0FF);
        acc("R7", 0, 3'd3, 1'b0, 8'h00, 12'h100); idle();
        check("R7", pv(0), 12'h100);
    endtask

    task automatic t_priority();
        dw_en = 1'b1; dw_sel = 1'b0; dw_hi = 1'b0; dw_data = 8'h40;
        acc("R9", 0, 3'd1, 1'b0, 8'h00, 12'h100); idle();
        check("R9", pv(0), 12'h140);
        dw_en = 1'b1; dw_sel = 1'b0; dw_hi = 1'b1; dw_data = 8'h02;
        acc("R9", 0, 3'd2, 1'b0, 8'h00, 12'h140); idle();
        check("R9", pv(0), 12'h240);
        dw_en = 1'b1; dw_sel = 1'b1; dw_hi = 1'b0; dw_data = 8'h3C;
        acc("R10", 0, 3'd1, 1'b0, 8'h00, 12'h240); idle();
        check("R10", pv(0), 12'h241);
        check("R10", pv(1), 12'hF3C);
    endtask

    task automatic t_invalid();
        for (int m = 5; m < 8; m++) begin
            acc_en = 1'b1; acc_sel = 1'b0; acc_mode = 3'(m); acc_we = m[0];
            #1;
            check("R11", {mem_rd, mem_wr}, 2'b00);
            step();
            check("R11", pv(0), 12'h241);
        end
        idle();
        #1;
        check("R11", {mem_rd, mem_wr}, 2'b00);
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_direct();
        t_modes();
        t_wrap();
        t_priority();
        t_invalid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule